// File: doc/BRIEF.md
# Wakeup Countdown Timer Register Bank

This block is the wakeup timer slice of a real-time clock register file. Software programs a 24-bit start value through a byte-wide register port and picks one of four tick sources. It then sets a run bit, and the block counts down by one on each selected tick. The tick sources are single-cycle enable pulses produced elsewhere in the chip.

When a tick arrives while the count holds 1, the block records a sticky expiry event. The counter then restarts from the programmed start value and keeps running. If the interrupt enable is set, an active-low interrupt line goes low. The block also keeps a sticky low-supply flag, which is driven by an external detector input, and two control bytes whose spare bits are plain storage. The read data is combinational from the address, so the serial front end that surrounds the block can sample it in the same cycle.

Top module: `rtc_wakeup_timer`

## Requirements
- R1: After reset, address 0Dh reads 02h, 0Eh reads 02h (low-supply flag at bit 1 set), 0Fh reads 40h, all live count bytes read 00h, and irq_n is 1.
- R2: Bytes written to 1Ch (bits 7:0), 1Dh (bits 15:8) and 1Eh (bits 23:16) form the 24-bit start value, and they read back unchanged from those addresses.
- R3: In the cycle after the run bit (bit 4 of 0Dh) changes from 0 to 1, the live count equals the start value. The live count reads at 0Bh (bits 7:0), 0Ch (bits 15:8) and 1Fh (bits 23:16).
- R4: While running, each pulse on the tick input chosen by bits 1:0 of 0Dh (00 picks tick_in[0], 01 picks tick_in[1], 10 picks tick_in[2], 11 picks tick_in[3]) lowers the count by one. Pulses on the other tick inputs leave the count unchanged.
- R5: A selected tick while the count is 1 sets the expiry flag (bit 4 of 0Eh) and reloads the count from the start value.
- R6: irq_n is 0 exactly when the expiry flag and the interrupt enable (bit 4 of 0Fh) are both 1.
- R7: Writing 1 to a flag bit of 0Eh leaves that bit unchanged. Writing 0 clears it.
- R8: An expiry in the same cycle as a write of 0Eh leaves the expiry flag at 1, whatever value is written to it.
- R9: A high level on low_volt sets the low-supply flag (bit 1 of 0Eh). The flag stays set until 0 is written to it.
- R10: Every bit of 0Dh and 0Fh, including the test bit 7 of 0Dh, reads back as last written.
- R11: While the run bit is 0, ticks leave the count unchanged.
- R12: With a start value of zero, ticks leave the count at zero, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| tick_in | input | 4 | Single-cycle tick-enable pulses, one per source |
| low_volt | input | 1 | Low-supply event from an external detector |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
The assertions assume that tick_in, low_volt and the register port change only between rising edges. They also assume that each tick is a single-cycle pulse, so one pulse yields exactly one decrement. The bench drives all inputs on the falling edge and holds each tick high for one full cycle only. It issues at most one register write per cycle and raises a tick in the same cycle as a write only in the deliberate collision case.

// File: rtl/rtc_wt_pkg.sv
package rtc_wt_pkg;
   localparam logic [7:0] ADDR_CTRL_A = 8'h0D;
   localparam logic [7:0] ADDR_FLAGS  = 8'h0E;
   localparam logic [7:0] ADDR_CTRL_B = 8'h0F;

   localparam int RUN_BIT    = 4;
   localparam int IRQEN_BIT  = 4;
   localparam int EXPF_BIT   = 4;
   localparam int LOWV_BIT   = 1;

   localparam logic [7:0] CTRL_A_RST = 8'h02;
   localparam logic [7:0] CTRL_B_RST = 8'h40;

   function automatic logic [7:0] preset_addr(input int idx);
      case (idx)
         0:       preset_addr = 8'h1C;
         1:       preset_addr = 8'h1D;
         default: preset_addr = 8'h1E;
      endcase
   endfunction

   function automatic logic [7:0] count_addr(input int idx);
      case (idx)
         0:       count_addr = 8'h0B;
         1:       count_addr = 8'h0C;
         default: count_addr = 8'h1F;
      endcase
   endfunction
endpackage

// File: rtl/rtc_wt_regs.sv
module rtc_wt_regs
   import rtc_wt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] ctrl_a,
   output logic [DATA_W-1:0] ctrl_b,
   output logic [CNT_W-1:0]  preset
);
   localparam int NBYTES = CNT_W / DATA_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_a <= DATA_W'(CTRL_A_RST);
         ctrl_b <= DATA_W'(CTRL_B_RST);
      end else if (reg_wr) begin
         if (reg_addr == ADDR_CTRL_A) ctrl_a <= reg_wdata;
         if (reg_addr == ADDR_CTRL_B) ctrl_b <= reg_wdata;
      end
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_preset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            preset[b*DATA_W +: DATA_W] <= '0;
         else if (reg_wr && reg_addr == preset_addr(b))
            preset[b*DATA_W +: DATA_W] <= reg_wdata;
      end
   end
endmodule

// File: rtl/rtc_wt_counter.sv
module rtc_wt_counter #(
   parameter int CNT_W = 24,
   parameter int SEL_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_en,
   input  logic [SEL_W-1:0]     src_sel,
   input  logic [(1<<SEL_W)-1:0] tick_vec,
   input  logic [CNT_W-1:0]     preset,
   output logic [CNT_W-1:0]     count,
   output logic                 run_q,
   output logic                 tick_sel,
   output logic                 expire
);
   localparam int NUM_SRC = 1 << SEL_W;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = tick_vec[i] && (src_sel == SEL_W'(i));
   end

   assign tick_sel = |hit;
   assign expire   = run_en && run_q && tick_sel && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         count <= '0;
      end else begin
         run_q <= run_en;
         if (run_en && !run_q)
            count <= preset;
         else if (run_en && tick_sel && count != '0)
            count <= (count == ONE) ? preset : count - ONE;
      end
   end
endmodule

// File: rtl/rtc_wt_flags.sv
module rtc_wt_flags
   import rtc_wt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flags_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              expire,
   input  logic              low_volt,
   input  logic              irq_en,
   output logic              exp_flag,
   output logic              lowv_flag,
   output logic              irq_n
);
   logic clr_exp, clr_lowv;

   assign clr_exp  = flags_wr && !reg_wdata[EXPF_BIT];
   assign clr_lowv = flags_wr && !reg_wdata[LOWV_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_flag  <= 1'b0;
         lowv_flag <= 1'b1;
      end else begin
         if (expire)       exp_flag <= 1'b1;
         else if (clr_exp) exp_flag <= 1'b0;
         if (low_volt)      lowv_flag <= 1'b1;
         else if (clr_lowv) lowv_flag <= 1'b0;
      end
   end

   assign irq_n = !(exp_flag && irq_en);
endmodule

// File: rtl/rtc_wakeup_timer.sv
module rtc_wakeup_timer
   import rtc_wt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 24,
   parameter int SEL_W  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [7:0]            reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [(1<<SEL_W)-1:0] tick_in,
   input  logic                  low_volt,
   output logic                  irq_n
);
   localparam int NBYTES = CNT_W / DATA_W;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("DATA_W must be 8 for the byte register map");
   end
   if (NBYTES != 3 || CNT_W % DATA_W != 0) begin : g_bad_cnt_w
      $error("CNT_W must span exactly three register bytes");
   end
   if (SEL_W < 1 || SEL_W > 2) begin : g_bad_sel_w
      $error("SEL_W must be 1 or 2");
   end

   logic [DATA_W-1:0] ctrl_a, ctrl_b;
   logic [CNT_W-1:0]  preset, count;
   logic              run_en, run_q, tick_sel, expire, irq_en;
   logic              exp_flag, lowv_flag, flags_wr;

   assign run_en   = ctrl_a[RUN_BIT];
   assign irq_en   = ctrl_b[IRQEN_BIT];
   assign flags_wr = reg_wr && (reg_addr == ADDR_FLAGS);

   rtc_wt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .preset(preset)
   );

   rtc_wt_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_counter (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(ctrl_a[SEL_W-1:0]),
      .tick_vec(tick_in), .preset(preset), .count(count), .run_q(run_q),
      .tick_sel(tick_sel), .expire(expire)
   );

   rtc_wt_flags #(.DATA_W(DATA_W)) i_flags (
      .clk(clk), .rst_n(rst_n), .flags_wr(flags_wr), .reg_wdata(reg_wdata),
      .expire(expire), .low_volt(low_volt), .irq_en(irq_en),
      .exp_flag(exp_flag), .lowv_flag(lowv_flag), .irq_n(irq_n)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL_A: reg_rdata = ctrl_a;
         ADDR_CTRL_B: reg_rdata = ctrl_b;
         ADDR_FLAGS: begin
            reg_rdata[EXPF_BIT] = exp_flag;
            reg_rdata[LOWV_BIT] = lowv_flag;
         end
         default: ;
      endcase
      for (int b = 0; b < NBYTES; b++) begin
         if (reg_addr == preset_addr(b)) reg_rdata = preset[b*DATA_W +: DATA_W];
         if (reg_addr == count_addr(b))  reg_rdata = count[b*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/rtc_wt_checker.sv
module rtc_wt_checker #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             run_q,
   input logic             tick_sel,
   input logic             expire,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] preset,
   input logic             exp_flag,
   input logic             lowv_flag,
   input logic             flags_wr,
   input logic [7:0]       reg_wdata,
   input logic             low_volt,
   input logic             irq_n
);
   // R3: a rising run bit loads the start value
   p_load_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !run_q) |=> (count == $past(preset)));

   // R4: a selected tick above one lowers the count by one
   p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && run_q && tick_sel && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

   // R5: expiry reloads and raises the flag
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (count == $past(preset) && exp_flag));

   // R5: the flag only rises after an expiry
   p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_flag) |-> $past(expire));

   // R6: interrupt low only while the flag is set
   p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> exp_flag);

   // R7: without a clearing write the flag holds
   p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_flag && !(flags_wr && !reg_wdata[4])) |=> exp_flag);

   // R9: a low-supply event sets its flag
   p_lowv_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      low_volt |=> lowv_flag);

   // R11: a stopped timer keeps its count
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(count));
endmodule

bind rtc_wakeup_timer rtc_wt_checker #(.CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .run_q(run_q),
   .tick_sel(tick_sel), .expire(expire), .count(count), .preset(preset),
   .exp_flag(exp_flag), .lowv_flag(lowv_flag), .flags_wr(flags_wr),
   .reg_wdata(reg_wdata), .low_volt(low_volt), .irq_n(irq_n)
);

// File: tb/test_rtc_wakeup_timer.sv
`timescale 1ns/1ps
module test_rtc_wakeup_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [3:0] tick_in = 4'h0;
   logic       low_volt = 1'b0;
   logic       irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rtc_wakeup_timer i_rtc_wakeup_timer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_in(tick_in),
      .low_volt(low_volt), .irq_n(irq_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic tick(input int idx);
      @(negedge clk);
      tick_in[idx] = 1'b1;
      @(negedge clk);
      tick_in = 4'h0;
   endtask

   task automatic read_count(output logic [23:0] c);
      logic [7:0] b0, b1, b2;
      rd(8'h0B, b0); rd(8'h0C, b1); rd(8'h1F, b2);
      c = {b2, b1, b0};
   endtask

   task automatic set_preset(input logic [23:0] v);
      wr(8'h1C, v[7:0]); wr(8'h1D, v[15:8]); wr(8'h1E, v[23:16]);
   endtask

   task automatic start(input logic [7:0] ctrl);
      wr(8'h0D, ctrl);
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d; logic [23:0] c;
      rd(8'h0D, d); check("R1 ctrl_a", d, 8'h02);
      rd(8'h0E, d); check("R1 flags", d, 8'h02);
      rd(8'h0F, d); check("R1 ctrl_b", d, 8'h40);
      read_count(c); check("R1 count", c, 24'h0);
      check("R1 irq_n", irq_n, 1'b1);
   endtask

   task automatic t_preset;
      logic [7:0] d;
      set_preset(24'h123456);
      rd(8'h1C, d); check("R2 preset low", d, 8'h56);
      rd(8'h1D, d); check("R2 preset mid", d, 8'h34);
      rd(8'h1E, d); check("R2 preset high", d, 8'h12);
   endtask

   task automatic t_load_and_tick;
      logic [23:0] c;
      start(8'h12);
      read_count(c); check("R3 load", c, 24'h123456);
      tick(2); read_count(c); check("R4 sel10 tick2", c, 24'h123455);
      tick(0); read_count(c); check("R4 unselected tick0", c, 24'h123455);
      wr(8'h0D, 8'h10);
      tick(0); read_count(c); check("R4 sel00 tick0", c, 24'h123454);
      tick(2); read_count(c); check("R4 unselected tick2", c, 24'h123454);
      wr(8'h0D, 8'h11);
      tick(1); read_count(c); check("R4 sel01 tick1", c, 24'h123453);
      wr(8'h0D, 8'h13);
      tick(3); read_count(c); check("R4 sel11 tick3", c, 24'h123452);
   endtask

   task automatic t_idle;
      logic [23:0] c;
      wr(8'h0D, 8'h03);
      tick(3); read_count(c); check("R11 stopped", c, 24'h123452);
   endtask

   task automatic t_expire;
      logic [23:0] c; logic [7:0] d;
      set_preset(24'h000003);
      wr(8'h0F, 8'h50);
      start(8'h10);
      read_count(c); check("R3 reload start", c, 24'h3);
      tick(0); tick(0);
      read_count(c); check("R4 down to one", c, 24'h1);
      rd(8'h0E, d); check("R5 no flag yet", d, 8'h02);
      check("R6 irq idle", irq_n, 1'b1);
      tick(0);
      rd(8'h0E, d); check("R5 flag set", d, 8'h12);
      read_count(c); check("R5 reload", c, 24'h3);
      check("R6 irq low", irq_n, 1'b0);
   endtask

   task automatic t_flag_write;
      logic [7:0] d;
      wr(8'h0E, 8'hFF);
      rd(8'h0E, d); check("R7 write ones keep", d, 8'h12);
      wr(8'h0F, 8'h40);
      check("R6 irq masked", irq_n, 1'b1);
      wr(8'h0F, 8'h50);
      check("R6 irq unmasked", irq_n, 1'b0);
      wr(8'h0E, 8'h02);
      rd(8'h0E, d); check("R7 clear flag", d, 8'h02);
      check("R6 irq after clear", irq_n, 1'b1);
      wr(8'h0E, 8'h00);
      rd(8'h0E, d); check("R9 clear lowv", d, 8'h00);
   endtask

   task automatic t_collide;
      logic [7:0] d;
      tick(0); tick(0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'h0E; reg_wdata = 8'h00; tick_in[0] = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; tick_in = 4'h0;
      rd(8'h0E, d); check("R8 set beats clear", d, 8'h10);
      wr(8'h0E, 8'h00);
      rd(8'h0E, d); check("R7 clear after collide", d, 8'h00);
   endtask

   task automatic t_lowv;
      logic [7:0] d;
      @(negedge clk); low_volt = 1'b1;
      @(negedge clk); low_volt = 1'b0;
      repeat (5) @(negedge clk);
      rd(8'h0E, d); check("R9 lowv sticky", d, 8'h02);
      wr(8'h0E, 8'hFF);
      rd(8'h0E, d); check("R9 lowv keep on one", d, 8'h02);
   endtask

   task automatic t_test_bit;
      logic [7:0] d;
      wr(8'h0D, 8'hA0);
      rd(8'h0D, d); check("R10 ctrl_a readback", d, 8'hA0);
      wr(8'h0F, 8'h8F);
      rd(8'h0F, d); check("R10 ctrl_b readback", d, 8'h8F);
      wr(8'h0D, 8'h00);
      wr(8'h0F, 8'h40);
   endtask

   task automatic t_zero;
      logic [23:0] c; logic [7:0] d;
      wr(8'h0E, 8'h00);
      set_preset(24'h0);
      start(8'h10);
      tick(0); tick(0);
      read_count(c); check("R12 zero hold", c, 24'h0);
      rd(8'h0E, d); check("R12 no expiry", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_preset();
      t_load_and_tick();
      t_idle();
      t_expire();
      t_flag_write();
      t_collide();
      t_lowv();
      t_test_bit();
      t_zero();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule